// File: doc/BRIEF.md
# BCD Time-of-Day Calendar Counter

This block is a real-time clock core. It keeps seconds, minutes, hours, weekday, day of month, month and a two-digit year, all in packed BCD except the weekday, which is a plain number from 0 to 6. Counting runs in 24-hour form and covers the years 00 to 99.

The one-second tick comes from one of two sources. In slow mode it is derived from a 32.768 kHz strobe, `SLOW_PER_SEC` strobes per second. In compare mode it is derived from a reference strobe, with one second every (compare value + 1) strobes. The compare mode is meant for reference rates from 32000 Hz up to 2^22 Hz.

Software reaches the core through a small register port: a write strobe, an address and write data, with read data available combinationally. Starting the counter and holding it each use a request bit. A matching status bit follows that request only after a number of slow strobes. Time and calendar words can be loaded only while the hold status is set. A separate seconds register lets software detect a rollover between two reads of the time and calendar words.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset the control and hold registers read 0, the time word reads 0x000000, the calendar word reads 0x00010100 (year 00, month 01, day 01, weekday 0), the compare register reads `CMP_RESET`, and `time_valid` is low.
- R2: Address 2 reads the time word with BCD hours in bits 23:16, minutes in 15:8 and seconds in 7:0. Address 4 reads the live BCD seconds in bits 7:0, with zeros above.
- R3: Each second tick advances the seconds. Seconds and minutes wrap from 59 to 00 with a carry. Hours wrap from 23 to 00 and carry into the day.
- R4: The calendar word at address 3 holds the BCD year in bits 31:24, the BCD month in 23:16, the BCD day in 15:8 and the weekday in 3:0. The day wraps to 01 after the last day of the month, and February has 29 days when the year is divisible by 4. The month wraps from 12 to 01 and carries into the year. The year wraps from 99 to 00, and the weekday steps on every day carry, wrapping from 6 to 0.
- R5: In slow mode (control bit 2 = 0) a second tick, visible on `second_pulse`, occurs on every `SLOW_PER_SEC`-th slow strobe while the counter runs.
- R6: In compare mode (control bit 2 = 1) a second tick occurs on every (compare value + 1)-th reference strobe while the counter runs. The compare value sits in bits `CMP_W`-1:0 of address 5.
- R7: Bit 0 of address 1 is the hold request and bit 1 is the hold status. The status takes the request value after `HS_STAGES` slow strobes. No second tick occurs and the time does not change while the hold status is set. Writing 0 releases the hold.
- R8: Bit 0 of address 0 is the enable request and bit 1 is the enable status. The status follows the request after `HS_STAGES` slow strobes. Second ticks occur only while the enable status is set and the hold status is clear.
- R9: Writes to the time word (address 2) and the calendar word (address 3) take effect only while the hold status is set. At other times they leave both words unchanged.
- R10: `time_valid` is high exactly when the enable status is set and both the hold request and the hold status are clear.
- R11: The sub-second prescaler restarts from zero whenever the counter is stopped or held, so the first tick after a start comes a full second later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | One-cycle strobe at the 32.768 kHz rate |
| ref_tick | input | 1 | One-cycle strobe at the reference clock rate |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| time_valid | output | 1 | Time and calendar may be trusted |
| second_pulse | output | 1 | High in the cycle in which a second tick is applied |

## Verification
The assertions check on every cycle that no tick happens while the counter is held or disabled, and that both status bits change only on a slow strobe. They also check that a held counter stays frozen, that a write made while the counter is not held leaves the time unchanged, and that seconds, midnight and weekday wrap correctly whenever those wraps occur. Month lengths, leap Februaries and the rollover from year 99 to 00 only show up in the bench's scenarios. The same is true of the exact cycle on which a status bit settles and the tick period in each source mode. The bench loads chosen dates into the counter and compares every output against its behavioural model on every clock.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_HOLD = 3'd1;
  localparam logic [2:0] A_TIME = 3'd2;
  localparam logic [2:0] A_CAL  = 3'd3;
  localparam logic [2:0] A_SEC  = 3'd4;
  localparam logic [2:0] A_CMP  = 3'd5;

  typedef struct packed {
    logic [7:0] hr;
    logic [7:0] mn;
    logic [7:0] sc;
  } rtc_time_t;

  typedef struct packed {
    logic [7:0] yr;
    logic [7:0] mo;
    logic [7:0] dy;
    logic [3:0] wd;
  } rtc_cal_t;

  // Add one to a two-digit packed BCD value (caller handles the wrap).
  function automatic logic [7:0] bcd_inc(input logic [7:0] x);
    if (x[3:0] == 4'd9) return {x[7:4] + 4'd1, 4'd0};
    return {x[7:4], x[3:0] + 4'd1};
  endfunction

  function automatic logic [6:0] bcd_to_bin(input logic [7:0] x);
    return 7'(x[7:4]) * 7'd10 + 7'(x[3:0]);
  endfunction

  // Last day of a month, in BCD, for a BCD month and BCD two-digit year.
  function automatic logic [7:0] last_day(input logic [7:0] mo, input logic [7:0] yr);
    logic [6:0] ybin;
    ybin = bcd_to_bin(yr);
    case (mo)
      8'h02:                      return (ybin[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_handshake.sv
module rtc_handshake #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic req,
  output logic sts
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    sh <= '0;
        else if (tick) sh <= req;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    sh <= '0;
        else if (tick) sh <= {sh[STAGES-2:0], req};
      end
    end
  endgenerate

  assign sts = sh[STAGES-1];
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int W = 22
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         step,
  input  logic [W-1:0] term,
  output logic         sec_pulse
);
  logic [W-1:0] cnt;
  logic         at_end;

  assign at_end    = (cnt >= term);
  assign sec_pulse = run & step & at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!run) cnt <= '0;
    else if (step) cnt <= at_end ? '0 : cnt + W'(1);
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        wr_time,
  input  logic        wr_cal,
  input  logic [31:0] wdata,
  output rtc_time_t   tm,
  output rtc_cal_t    cal,
  output logic        ev_day
);
  logic sc_end, mn_end, hr_end, dy_end, mo_end, yr_end, wd_end;
  logic ev_min, ev_hr, ev_mon, ev_yr;

  assign sc_end = (tm.sc == 8'h59);
  assign mn_end = (tm.mn == 8'h59);
  assign hr_end = (tm.hr == 8'h23);
  assign dy_end = (cal.dy == last_day(cal.mo, cal.yr));
  assign mo_end = (cal.mo == 8'h12);
  assign yr_end = (cal.yr == 8'h99);
  assign wd_end = (cal.wd == 4'd6);

  assign ev_min = tick & sc_end;
  assign ev_hr  = ev_min & mn_end;
  assign ev_day = ev_hr & hr_end;
  assign ev_mon = ev_day & dy_end;
  assign ev_yr  = ev_mon & mo_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tm <= '0;
    end else if (wr_time) begin
      tm.hr <= wdata[23:16];
      tm.mn <= wdata[15:8];
      tm.sc <= wdata[7:0];
    end else begin
      if (tick)   tm.sc <= sc_end ? 8'h00 : bcd_inc(tm.sc);
      if (ev_min) tm.mn <= mn_end ? 8'h00 : bcd_inc(tm.mn);
      if (ev_hr)  tm.hr <= hr_end ? 8'h00 : bcd_inc(tm.hr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal.yr <= 8'h00;
      cal.mo <= 8'h01;
      cal.dy <= 8'h01;
      cal.wd <= 4'd0;
    end else if (wr_cal) begin
      cal.yr <= wdata[31:24];
      cal.mo <= wdata[23:16];
      cal.dy <= wdata[15:8];
      cal.wd <= wdata[3:0];
    end else begin
      if (ev_day) cal.wd <= wd_end ? 4'd0 : cal.wd + 4'd1;
      if (ev_day) cal.dy <= dy_end ? 8'h01 : bcd_inc(cal.dy);
      if (ev_mon) cal.mo <= mo_end ? 8'h01 : bcd_inc(cal.mo);
      if (ev_yr)  cal.yr <= yr_end ? 8'h00 : bcd_inc(cal.yr);
    end
  end
endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
  import rtc_pkg::*;
#(
  parameter int SLOW_PER_SEC = 32768,
  parameter int HS_STAGES    = 2,
  parameter int CMP_W        = 22,
  parameter int CMP_RESET    = 32767
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        slow_tick,
  input  logic        ref_tick,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        time_valid,
  output logic        second_pulse
);
  localparam int SPS_W = (SLOW_PER_SEC > 1) ? $clog2(SLOW_PER_SEC) : 1;
  localparam int PRE_W = (SPS_W > CMP_W) ? SPS_W : CMP_W;

  logic             en_req, hold_req, cmp_mode;
  logic [CMP_W-1:0] cmp_val;
  logic             en_sts, hold_sts, running, step, sec_pulse, ev_day;
  logic [PRE_W-1:0] term;
  rtc_time_t        cur_tm;
  rtc_cal_t         cur_cal;
  logic [23:0]      time_word;
  logic [31:0]      cal_word;
  logic             wr_time, wr_cal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_req   <= 1'b0;
      cmp_mode <= 1'b0;
      hold_req <= 1'b0;
      cmp_val  <= CMP_W'(CMP_RESET);
    end else if (reg_wr) begin
      case (reg_addr)
        A_CTRL: begin
          en_req   <= reg_wdata[0];
          cmp_mode <= reg_wdata[2];
        end
        A_HOLD:  hold_req <= reg_wdata[0];
        A_CMP:   cmp_val  <= reg_wdata[CMP_W-1:0];
        default: ;
      endcase
    end
  end

  rtc_handshake #(.STAGES(HS_STAGES)) u_en_hs (
    .clk(clk), .rst_n(rst_n), .tick(slow_tick), .req(en_req), .sts(en_sts));

  rtc_handshake #(.STAGES(HS_STAGES)) u_hold_hs (
    .clk(clk), .rst_n(rst_n), .tick(slow_tick), .req(hold_req), .sts(hold_sts));

  assign running = en_sts & ~hold_sts;
  assign step    = cmp_mode ? ref_tick : slow_tick;
  assign term    = cmp_mode ? PRE_W'(cmp_val) : PRE_W'(SLOW_PER_SEC - 1);

  rtc_prescaler #(.W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(running), .step(step),
    .term(term), .sec_pulse(sec_pulse));

  assign wr_time = reg_wr & hold_sts & (reg_addr == A_TIME);
  assign wr_cal  = reg_wr & hold_sts & (reg_addr == A_CAL);

  rtc_calendar u_cal (
    .clk(clk), .rst_n(rst_n), .tick(sec_pulse), .wr_time(wr_time),
    .wr_cal(wr_cal), .wdata(reg_wdata), .tm(cur_tm), .cal(cur_cal),
    .ev_day(ev_day));

  assign time_word = {cur_tm.hr, cur_tm.mn, cur_tm.sc};
  assign cal_word  = {cur_cal.yr, cur_cal.mo, cur_cal.dy, 4'h0, cur_cal.wd};

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {29'd0, cmp_mode, en_sts, en_req};
      A_HOLD:  reg_rdata = {30'd0, hold_sts, hold_req};
      A_TIME:  reg_rdata = {8'h00, time_word};
      A_CAL:   reg_rdata = cal_word;
      A_SEC:   reg_rdata = {24'd0, cur_tm.sc};
      A_CMP:   reg_rdata = 32'(cmp_val);
      default: reg_rdata = 32'd0;
    endcase
  end

  assign time_valid   = en_sts & ~hold_req & ~hold_sts;
  assign second_pulse = sec_pulse;
endmodule

// File: rtl/rtc_bcd_core_chk.sv
module rtc_bcd_core_chk
  import rtc_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        slow_tick,
  input logic        reg_wr,
  input logic [2:0]  reg_addr,
  input logic        en_sts,
  input logic        hold_sts,
  input logic        sec_pulse,
  input logic        ev_day,
  input logic [23:0] time_word,
  input logic [3:0]  wday
);
  // R7: a held counter never ticks
  p_hold_no_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_sts |-> !sec_pulse);

  // R8: a disabled counter never ticks
  p_off_no_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_sts |-> !sec_pulse);

  // R7: hold status moves only on a slow strobe
  p_hold_sts_slow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !slow_tick |=> $stable(hold_sts));

  // R8: enable status moves only on a slow strobe
  p_en_sts_slow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !slow_tick |=> $stable(en_sts));

  // R7: held time stays frozen unless written
  p_held_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_sts && !reg_wr) |=> $stable(time_word));

  // R9: time write without hold has no effect
  p_wr_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_TIME && !hold_sts && !sec_pulse) |=> $stable(time_word));

  // R3: seconds wrap 59 to 00
  p_sec_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && time_word[7:0] == 8'h59) |=> (time_word[7:0] == 8'h00));

  // R3: a day carry leaves the time at midnight
  p_midnight_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_day |=> (time_word == 24'h000000));

  // R4: weekday wraps 6 to 0
  p_wday_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_day && wday == 4'd6) |=> (wday == 4'd0));
endmodule

bind rtc_bcd_core rtc_bcd_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .en_sts(en_sts), .hold_sts(hold_sts),
  .sec_pulse(sec_pulse), .ev_day(ev_day), .time_word(time_word),
  .wday(cal_word[3:0]));

// File: tb/sim_rtc_bcd_core.sv
`timescale 1ns/1ps
module sim_rtc_bcd_core;
  localparam int SPS = 4;
  localparam int ST  = 2;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        slow_tick = 0, ref_tick = 0;
  logic        reg_wr = 0;
  logic [2:0]  reg_addr = 3'd2;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        time_valid, second_pulse;

  int checks = 0, errors = 0, cyc = 0, ncyc = 0, ref_div = 1;
  bit cmp_on = 0, done = 0;

  // reference model state
  int m_en = 0, m_mode = 0, m_hold = 0, m_cmp = 3, m_pc = 0;
  int sc = 0, mn = 0, hr = 0, wd = 0, dy = 1, mo = 1, yr = 0;
  int enq[$], hq[$];

  rtc_bcd_core #(.SLOW_PER_SEC(SPS), .HS_STAGES(ST), .CMP_W(22), .CMP_RESET(3)) u0 (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .ref_tick(ref_tick),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .time_valid(time_valid), .second_pulse(second_pulse));

  always #2 clk = ~clk;

  function automatic int bcd(input int v);
    return ((v / 10) << 4) | (v % 10);
  endfunction
  function automatic int unbcd(input int v);
    return ((v >> 4) & 15) * 10 + (v & 15);
  endfunction
  function automatic int dim(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic int en_s();   return enq[ST-1]; endfunction
  function automatic int hold_s(); return hq[ST-1];  endfunction
  function automatic bit m_pulse();
    int term;
    bit stp;
    term = m_mode ? m_cmp : SPS - 1;
    stp  = m_mode ? ref_tick : slow_tick;
    return (en_s() != 0) && (hold_s() == 0) && stp && (m_pc >= term);
  endfunction

  task automatic advance();
    sc++;
    if (sc == 60) begin
      sc = 0; mn++;
      if (mn == 60) begin
        mn = 0; hr++;
        if (hr == 24) begin
          hr = 0; wd = (wd + 1) % 7; dy++;
          if (dy > dim(mo, yr)) begin
            dy = 1; mo++;
            if (mo == 13) begin mo = 1; yr = (yr + 1) % 100; end
          end
        end
      end
    end
  endtask

  initial begin
    for (int i = 0; i < ST; i++) begin enq.push_back(0); hq.push_back(0); end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_mode = 0; m_hold = 0; m_cmp = 3; m_pc = 0;
      sc = 0; mn = 0; hr = 0; wd = 0; dy = 1; mo = 1; yr = 0;
      for (int i = 0; i < ST; i++) begin enq[i] = 0; hq[i] = 0; end
    end else begin
      bit pul, run, stp, hs_old;
      int term;
      pul    = m_pulse();
      run    = (en_s() != 0) && (hold_s() == 0);
      stp    = m_mode ? ref_tick : slow_tick;
      term   = m_mode ? m_cmp : SPS - 1;
      hs_old = (hold_s() != 0);
      if (!run) m_pc = 0;
      else if (stp) m_pc = (m_pc >= term) ? 0 : m_pc + 1;
      if (pul) advance();
      if (slow_tick) begin
        enq.push_front(m_en);  void'(enq.pop_back());
        hq.push_front(m_hold); void'(hq.pop_back());
      end
      if (reg_wr) begin
        case (reg_addr)
          3'd0: begin m_en = reg_wdata[0]; m_mode = reg_wdata[2]; end
          3'd1: m_hold = reg_wdata[0];
          3'd2: if (hs_old) begin
                  hr = unbcd(reg_wdata[23:16]); mn = unbcd(reg_wdata[15:8]);
                  sc = unbcd(reg_wdata[7:0]);
                end
          3'd3: if (hs_old) begin
                  yr = unbcd(reg_wdata[31:24]); mo = unbcd(reg_wdata[23:16]);
                  dy = unbcd(reg_wdata[15:8]);  wd = reg_wdata[3:0];
                end
          3'd5: m_cmp = reg_wdata[21:0];
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_rdata(input logic [2:0] a);
    case (a)
      3'd0: return {29'd0, 1'(m_mode), 1'(en_s()), 1'(m_en)};
      3'd1: return {30'd0, 1'(hold_s()), 1'(m_hold)};
      3'd2: return {8'h0, 8'(bcd(hr)), 8'(bcd(mn)), 8'(bcd(sc))};
      3'd3: return {8'(bcd(yr)), 8'(bcd(mo)), 8'(bcd(dy)), 4'h0, 4'(wd)};
      3'd4: return {24'd0, 8'(bcd(sc))};
      3'd5: return 32'(m_cmp);
      default: return 32'd0;
    endcase
  endfunction

  // drive strobes on the falling edge, compare shortly after
  always @(negedge clk) begin
    ncyc++;
    slow_tick = (ncyc % 3 == 0);
    ref_tick  = (ncyc % ref_div == 0);
    #1;
    if (cmp_on && !done) begin
      chk(m_mode ? "R6 second_pulse" : "R5 second_pulse", 32'(second_pulse), 32'(m_pulse()));
      chk("R10 time_valid", 32'(time_valid),
          32'((en_s() != 0) && m_hold == 0 && hold_s() == 0));
      case (reg_addr)
        3'd0: chk("R8 control word", reg_rdata, m_rdata(reg_addr));
        3'd1: chk("R7 hold word", reg_rdata, m_rdata(reg_addr));
        3'd2: chk("R3 time word", reg_rdata, m_rdata(reg_addr));
        3'd3: chk("R4 calendar word", reg_rdata, m_rdata(reg_addr));
        3'd4: chk("R2 seconds word", reg_rdata, m_rdata(reg_addr));
        default: chk("R11 prescaler/compare readback", reg_rdata, m_rdata(reg_addr));
      endcase
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0; reg_addr = 3'd2;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic load(input logic [31:0] t, input logic [31:0] c);
    wr(3'd1, 1); repeat (12) @(negedge clk);
    wr(3'd2, t); wr(3'd3, c); wr(3'd1, 0);
  endtask

  task automatic wait_midnight();
    logic [31:0] v;
    for (int i = 0; i < 600; i++) begin
      rd(3'd2, v);
      if (v == 32'h0) break;
    end
  endtask

  initial begin
    logic [31:0] v;
    repeat (5) @(negedge clk);
    rst_n = 1; cmp_on = 1;
    rd(3'd0, v); chk("R1 control after reset", v, 32'h0);
    rd(3'd2, v); chk("R1 time after reset", v, 32'h0);
    rd(3'd3, v); chk("R1 calendar after reset", v, 32'h00010100);
    rd(3'd5, v); chk("R1 compare after reset", v, 32'd3);
    chk("R1 time_valid after reset", 32'(time_valid), 32'd0);

    // R9: write without hold is ignored
    wr(3'd2, 32'h00123456);
    rd(3'd2, v); chk("R9 ignored time write", v, 32'h0);

    wr(3'd0, 1);
    wr(3'd1, 1); repeat (12) @(negedge clk);
    rd(3'd1, v); chk("R7 hold status set", v, 32'h3);
    chk("R10 invalid while held", 32'(time_valid), 32'd0);
    wr(3'd2, 32'h00235958); wr(3'd3, 32'h23022806);
    rd(3'd2, v); chk("R9 accepted time write", v, 32'h00235958);
    rd(3'd3, v); chk("R9 accepted calendar write", v, 32'h23022806);
    repeat (20) @(negedge clk);
    rd(3'd2, v); chk("R7 frozen while held", v, 32'h00235958);
    wr(3'd1, 0);
    wait_midnight();
    rd(3'd3, v); chk("R4 Feb 28 non-leap to Mar 01, wday 6 to 0", v, 32'h23030100);
    rd(3'd4, v); chk("R2 seconds register at midnight", v, 32'h0);

    load(32'h00235959, 32'h24022804);
    wait_midnight();
    rd(3'd3, v); chk("R4 leap Feb 29", v, 32'h24022905);

    load(32'h00235959, 32'h99123103);
    wait_midnight();
    rd(3'd3, v); chk("R4 year 99 to 00", v, 32'h00010104);

    load(32'h00235959, 32'h21043001);
    wait_midnight();
    rd(3'd3, v); chk("R4 30-day month", v, 32'h21050102);

    load(32'h00105959, 32'h21050102);
    repeat (40) @(negedge clk);
    rd(3'd2, v); chk("R3 minute carry into hour", v[23:8], 16'h1100);

    // compare mode
    wr(3'd5, 32'd5); ref_div = 2;
    wr(3'd0, 32'h5);
    rd(3'd5, v); chk("R6 compare readback", v, 32'd5);
    repeat (150) @(negedge clk);

    // disable
    wr(3'd0, 0); repeat (12) @(negedge clk);
    rd(3'd0, v); chk("R8 enable status cleared", v, 32'h0);
    repeat (30) @(negedge clk);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule